// File: doc/BRIEF.md
# Byte-Serial Scaled-Block Stream Sequencer

This block is the control sequencer for a byte-wide multiply-accumulate engine that works on blocks of 32 element pairs sharing one scale per operand. Two 8-bit input buses carry, in fixed cycle slots, a pair of header bytes, then an optional scale byte and an optional format/block-max byte for each operand, then the element pairs. The sequencer decodes the slots, keeps the per-operand configuration in registers, and raises one strobe per phase for the arithmetic datapath. That datapath is not part of this block. It reads the element bytes straight from the input buses whenever the stream strobe is high, and it hands its 32-bit accumulator back to the sequencer.

After the stream phase the sequencer runs one flush cycle and one calculate cycle. In the calculate cycle it copies the accumulator into a shadow register. It then shifts the shadow out on the 8-bit result bus over four cycles, most significant byte first, and returns to the header slot. Header bit 7 on bus A requests the short form, which skips both configuration cycles and keeps the stored configuration. Header bit 6 on bus B selects packed mode, which halves the stream phase. The full block takes 41 cycles and the short packed block takes 23.

A debug flag in the header has two effects. It echoes header byte A on the result bus during the flush cycle. It also drives a selectable probe byte on the result bus in the header, configuration and stream cycles. A clock enable freezes the whole machine.

Top module: `blkstream_seq`

## Requirements
- R1: While reset is asserted, and while the enable is held low after reset, `res_out` is 0, all four strobes are 0, and the scale, format, block-max and `pack_mode` outputs are 0.
- R2: A full block moves through these phases in order: 1 header cycle, 1 configuration-A cycle, 1 configuration-B cycle, 32 stream cycles, 1 flush cycle, 1 calculate cycle and 4 output cycles, 41 enabled cycles in all. `acc_clr` is high only in the header cycle, `elem_stb` only in the stream cycles, `flush_stb` only in the flush cycle and `calc_stb` only in the calculate cycle.
- R3: In the configuration-A cycle, `a_in` is stored as `scale_a`, and `b_in` is stored with bits [7:5] as `fmt_a` and bits [4:0] as the block-max index `bm_a`. The configuration-B cycle stores `scale_b`, `fmt_b` and `bm_b` in the same way.
- R4: When `a_in` bit 7 is 1 in the header cycle, the next cycle is the first stream cycle and the stored scale, format and block-max values keep their old values.
- R5: When `b_in` bit 6 is 1 in the header cycle, the stream phase lasts 16 cycles and `pack_mode` reads 1 until the next header. A short packed block takes 23 enabled cycles.
- R6: `acc_in` is sampled in the calculate cycle. The four output cycles show its bytes from bit 31 down to bit 0, and later changes on `acc_in` do not affect them.
- R7: When the debug flag is 0, `res_out` is 0 in every cycle that is not an output cycle. The debug flag is bit 6 of header byte A.
- R8: When the debug flag is 1, the flush cycle outputs header byte A unchanged. The calculate cycle outputs 0 whatever the debug flag.
- R9: When the debug flag is 1, the header, configuration and stream cycles output a probe byte chosen by header A bits [3:0]. The codes are: 0 gives {phase[2:0], count[4:0]}, where the phase codes are header 0, config A 1, config B 2, stream 3, flush 4, calculate 5 and output 6, and the count is the stream or output index (0 in other phases); 1 gives `exc_in`; 2 to 5 give `acc_in` bytes from most significant to least; 6 gives `lane0_in`; 7 gives `lane1_in`; 8 gives {en, acc_clr, elem_stb, flush_stb, calc_stb, 3'b000}; any other code gives 0. The header cycle uses the debug flag and selector of the previous block.
- R10: A cycle with `en` low advances no phase, stores no input byte and raises no strobe.
- R11: After the fourth output cycle the next cycle is a header cycle, so blocks run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for all state |
| a_in | input | 8 | Header A, scale A, scale B or element A |
| b_in | input | 8 | Header B, config A, config B or element B |
| acc_in | input | 32 | Accumulator from the datapath |
| exc_in | input | 8 | Datapath exception flags (probe source) |
| lane0_in | input | 8 | Lane 0 product byte (probe source) |
| lane1_in | input | 8 | Lane 1 product byte (probe source) |
| res_out | output | 8 | Result byte, echo or probe |
| acc_clr | output | 1 | Accumulator clear, header cycle |
| elem_stb | output | 1 | Element pair valid on the input buses |
| flush_stb | output | 1 | Flush cycle strobe |
| calc_stb | output | 1 | Calculate cycle strobe |
| pack_mode | output | 1 | Packed mode of the current block |
| scale_a | output | 8 | Stored scale A |
| scale_b | output | 8 | Stored scale B |
| fmt_a | output | 3 | Stored format A |
| bm_a | output | 5 | Stored block-max index A |
| fmt_b | output | 3 | Stored format B |
| bm_b | output | 5 | Stored block-max index B |

## Verification
A low enable can land on the same cycle as any phase function: a header capture, a configuration load, a stream strobe, the flush echo, the accumulator capture or a result byte. The bench provokes this by dropping `en` at random inside blocks, at rates from light to heavy, and by driving random bytes on both buses in every stalled cycle. A stalled cycle is judged correct only if it raises no strobe and leaves the output byte equal to the byte of that same phase. The stored configuration and the captured result must match the values given in enabled cycles, which shows that the random bytes were not taken in.

// File: rtl/blkstream_pkg.sv
`timescale 1ns/1ps
package blkstream_pkg;
  typedef enum logic [2:0] {
    PH_META   = 3'd0,
    PH_CFGA   = 3'd1,
    PH_CFGB   = 3'd2,
    PH_STREAM = 3'd3,
    PH_FLUSH  = 3'd4,
    PH_CALC   = 3'd5,
    PH_OUT    = 3'd6
  } phase_t;

  // header bit positions
  localparam int unsigned HA_SHORT  = 7;
  localparam int unsigned HA_DEBUG  = 6;
  localparam int unsigned HB_PACKED = 6;
  localparam int unsigned PSEL_W    = 4;

  // probe selector codes
  localparam logic [PSEL_W-1:0] PR_STATE = 4'd0;
  localparam logic [PSEL_W-1:0] PR_EXC   = 4'd1;
  localparam logic [PSEL_W-1:0] PR_ACC   = 4'd2;
  localparam logic [PSEL_W-1:0] PR_LANE0 = 4'd6;
  localparam logic [PSEL_W-1:0] PR_LANE1 = 4'd7;
  localparam logic [PSEL_W-1:0] PR_CTRL  = 4'd8;
endpackage

// File: rtl/blkstream_rst.sv
`timescale 1ns/1ps
module blkstream_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/blkstream_fsm.sv
`timescale 1ns/1ps
module blkstream_fsm
  import blkstream_pkg::*;
#(
  parameter int unsigned BLK_LEN   = 32,
  parameter int unsigned RES_BYTES = 4,
  parameter int unsigned CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             short_req,
  input  logic             packed_q,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             acc_clr,
  output logic             elem_stb,
  output logic             flush_stb,
  output logic             calc_stb
);
  localparam int unsigned FULL_LAST = BLK_LEN - 1;
  localparam int unsigned HALF_LAST = BLK_LEN / 2 - 1;
  localparam int unsigned OUT_LAST  = RES_BYTES - 1;

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] stream_last;

  assign stream_last = packed_q ? CNT_W'(HALF_LAST) : CNT_W'(FULL_LAST);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = '0;
    case (phase_q)
      PH_META:   phase_d = short_req ? PH_STREAM : PH_CFGA;
      PH_CFGA:   phase_d = PH_CFGB;
      PH_CFGB:   phase_d = PH_STREAM;
      PH_STREAM: begin
        if (cnt_q == stream_last) phase_d = PH_FLUSH;
        else                      cnt_d   = cnt_q + 1'b1;
      end
      PH_FLUSH:  phase_d = PH_CALC;
      PH_CALC:   phase_d = PH_OUT;
      PH_OUT: begin
        if (cnt_q == CNT_W'(OUT_LAST)) phase_d = PH_META;
        else                           cnt_d   = cnt_q + 1'b1;
      end
      default:   phase_d = PH_META;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_META;
      cnt_q   <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase     = phase_q;
  assign cnt       = cnt_q;
  assign acc_clr   = en && (phase_q == PH_META);
  assign elem_stb  = en && (phase_q == PH_STREAM);
  assign flush_stb = en && (phase_q == PH_FLUSH);
  assign calc_stb  = en && (phase_q == PH_CALC);
endmodule

// File: rtl/blkstream_cfg.sv
`timescale 1ns/1ps
module blkstream_cfg
  import blkstream_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  phase_t            phase,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] b_in,
  output logic [BYTE_W-1:0] hdr_a,
  output logic [BYTE_W-1:0] hdr_b,
  output logic [BYTE_W-1:0] scl_a,
  output logic [BYTE_W-1:0] scl_b,
  output logic [BYTE_W-1:0] cfg_a,
  output logic [BYTE_W-1:0] cfg_b
);
  logic ld_hdr, ld_a, ld_b;

  assign ld_hdr = en && (phase == PH_META);
  assign ld_a   = en && (phase == PH_CFGA);
  assign ld_b   = en && (phase == PH_CFGB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_a <= '0;
      hdr_b <= '0;
    end else if (ld_hdr) begin
      hdr_a <= a_in;
      hdr_b <= b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_a <= '0;
      cfg_a <= '0;
    end else if (ld_a) begin
      scl_a <= a_in;
      cfg_a <= b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_b <= '0;
      cfg_b <= '0;
    end else if (ld_b) begin
      scl_b <= a_in;
      cfg_b <= b_in;
    end
  end
endmodule

// File: rtl/blkstream_out.sv
`timescale 1ns/1ps
module blkstream_out
  import blkstream_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned RES_BYTES = 4,
  parameter int unsigned CNT_W     = 5,
  localparam int unsigned RES_W    = BYTE_W * RES_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  phase_t            phase,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] hdr_a,
  input  logic [RES_W-1:0]  acc_in,
  input  logic [BYTE_W-1:0] exc_in,
  input  logic [BYTE_W-1:0] lane0_in,
  input  logic [BYTE_W-1:0] lane1_in,
  input  logic [3:0]        strobes,
  output logic [RES_W-1:0]  shadow,
  output logic [BYTE_W-1:0] res_out
);
  logic              dbg;
  logic [PSEL_W-1:0] sel;
  logic [BYTE_W-1:0] probe, res_byte, acc_byte, st_byte, ctl_byte;
  logic [RES_W-1:0]  res_sh, acc_sh;
  logic [PSEL_W-1:0] acc_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         shadow <= '0;
    else if (en && (phase == PH_CALC))  shadow <= acc_in;
  end

  assign dbg      = hdr_a[HA_DEBUG];
  assign sel      = hdr_a[PSEL_W-1:0];
  assign res_sh   = shadow << (BYTE_W * cnt);
  assign res_byte = res_sh[RES_W-1 -: BYTE_W];
  assign acc_idx  = sel - PR_ACC;
  assign acc_sh   = acc_in << (BYTE_W * acc_idx);
  assign acc_byte = acc_sh[RES_W-1 -: BYTE_W];
  assign st_byte  = BYTE_W'({phase, cnt});
  assign ctl_byte = BYTE_W'({en, strobes, 3'b000});

  always_comb begin
    if (sel == PR_STATE)                                     probe = st_byte;
    else if (sel == PR_EXC)                                  probe = exc_in;
    else if (sel >= PR_ACC && acc_idx < PSEL_W'(RES_BYTES))  probe = acc_byte;
    else if (sel == PR_LANE0)                                probe = lane0_in;
    else if (sel == PR_LANE1)                                probe = lane1_in;
    else if (sel == PR_CTRL)                                 probe = ctl_byte;
    else                                                     probe = '0;
  end

  always_comb begin
    case (phase)
      PH_OUT:   res_out = res_byte;
      PH_FLUSH: res_out = dbg ? hdr_a : '0;
      PH_CALC:  res_out = '0;
      default:  res_out = dbg ? probe : '0;
    endcase
  end
endmodule

// File: rtl/blkstream_seq.sv
`timescale 1ns/1ps
module blkstream_seq
  import blkstream_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned BLK_LEN   = 32,
  parameter int unsigned RES_BYTES = 4,
  parameter int unsigned FMT_W     = 3,
  localparam int unsigned CNT_W    = $clog2(BLK_LEN),
  localparam int unsigned RES_W    = BYTE_W * RES_BYTES,
  localparam int unsigned BM_W     = BYTE_W - FMT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [BYTE_W-1:0] b_in,
  input  logic [RES_W-1:0]  acc_in,
  input  logic [BYTE_W-1:0] exc_in,
  input  logic [BYTE_W-1:0] lane0_in,
  input  logic [BYTE_W-1:0] lane1_in,
  output logic [BYTE_W-1:0] res_out,
  output logic              acc_clr,
  output logic              elem_stb,
  output logic              flush_stb,
  output logic              calc_stb,
  output logic              pack_mode,
  output logic [BYTE_W-1:0] scale_a,
  output logic [BYTE_W-1:0] scale_b,
  output logic [FMT_W-1:0]  fmt_a,
  output logic [BM_W-1:0]   bm_a,
  output logic [FMT_W-1:0]  fmt_b,
  output logic [BM_W-1:0]   bm_b
);
  logic              rst_s_n;
  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] hdr_a, hdr_b, cfg_a, cfg_b;
  logic [RES_W-1:0]  shadow;

  blkstream_rst #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  blkstream_fsm #(.BLK_LEN(BLK_LEN), .RES_BYTES(RES_BYTES), .CNT_W(CNT_W)) i_fsm (
    .clk(clk), .rst_n(rst_s_n), .en(en),
    .short_req(a_in[HA_SHORT]), .packed_q(hdr_b[HB_PACKED]),
    .phase(phase), .cnt(cnt),
    .acc_clr(acc_clr), .elem_stb(elem_stb),
    .flush_stb(flush_stb), .calc_stb(calc_stb)
  );

  blkstream_cfg #(.BYTE_W(BYTE_W)) i_cfg (
    .clk(clk), .rst_n(rst_s_n), .en(en), .phase(phase),
    .a_in(a_in), .b_in(b_in),
    .hdr_a(hdr_a), .hdr_b(hdr_b),
    .scl_a(scale_a), .scl_b(scale_b),
    .cfg_a(cfg_a), .cfg_b(cfg_b)
  );

  blkstream_out #(.BYTE_W(BYTE_W), .RES_BYTES(RES_BYTES), .CNT_W(CNT_W)) i_out (
    .clk(clk), .rst_n(rst_s_n), .en(en), .phase(phase), .cnt(cnt),
    .hdr_a(hdr_a), .acc_in(acc_in), .exc_in(exc_in),
    .lane0_in(lane0_in), .lane1_in(lane1_in),
    .strobes({acc_clr, elem_stb, flush_stb, calc_stb}),
    .shadow(shadow), .res_out(res_out)
  );

  assign pack_mode = hdr_b[HB_PACKED];
  assign fmt_a     = cfg_a[BYTE_W-1 -: FMT_W];
  assign bm_a      = cfg_a[BM_W-1:0];
  assign fmt_b     = cfg_b[BYTE_W-1 -: FMT_W];
  assign bm_b      = cfg_b[BM_W-1:0];
endmodule

// File: rtl/blkstream_chk.sv
`timescale 1ns/1ps
module blkstream_chk
  import blkstream_pkg::*;
#(
  parameter int unsigned BLK_LEN   = 32,
  parameter int unsigned RES_BYTES = 4,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned RES_W     = 32
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             en,
  input logic             short_req,
  input logic             packed_q,
  input logic             dbg,
  input phase_t           phase,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       res_out,
  input logic             acc_clr,
  input logic             elem_stb,
  input logic             flush_stb,
  input logic             calc_stb,
  input logic [RES_W-1:0] shadow
);
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({acc_clr, elem_stb, flush_stb, calc_stb}));

  a_r4_skip_cfg: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_META && en && short_req) |=> (phase == PH_STREAM));

  a_r5_half_stream: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_STREAM && packed_q && cnt == CNT_W'(BLK_LEN/2 - 1) && en) |=> (phase == PH_FLUSH));

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_OUT && $past(phase) == PH_OUT) |-> $stable(shadow));

  a_r7_quiet_out: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!dbg && phase != PH_OUT) |-> (res_out == 8'h00));

  a_r8_calc_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_CALC) |-> (res_out == 8'h00));

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en |=> ($stable(phase) && $stable(cnt)));

  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en |-> !(acc_clr || elem_stb || flush_stb || calc_stb));

  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    (phase == PH_OUT && cnt == CNT_W'(RES_BYTES - 1) && en) |=> (phase == PH_META));
endmodule

bind blkstream_seq blkstream_chk #(
  .BLK_LEN(BLK_LEN), .RES_BYTES(RES_BYTES), .CNT_W(CNT_W), .RES_W(RES_W)
) i_chk (
  .clk(clk), .rst_s_n(rst_s_n), .en(en),
  .short_req(a_in[7]), .packed_q(hdr_b[6]), .dbg(hdr_a[6]),
  .phase(phase), .cnt(cnt), .res_out(res_out),
  .acc_clr(acc_clr), .elem_stb(elem_stb), .flush_stb(flush_stb), .calc_stb(calc_stb),
  .shadow(shadow)
);

// File: tb/test_blkstream_seq.sv
`timescale 1ns/1ps
module test_blkstream_seq;
  import blkstream_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [7:0]  a_in, b_in, exc_in, lane0_in, lane1_in;
  logic [31:0] acc_in;
  logic [7:0]  res_out, scale_a, scale_b;
  logic        acc_clr, elem_stb, flush_stb, calc_stb, pack_mode;
  logic [2:0]  fmt_a, fmt_b;
  logic [4:0]  bm_a, bm_b;

  int n_chk = 0;
  int n_bad = 0;
  bit [7:0] prev_ma = 8'h00;
  bit [7:0] e_sa = 0, e_ca = 0, e_sb = 0, e_cb = 0;

  always #2.5 clk = ~clk;

  blkstream_seq i_blkstream_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .a_in(a_in), .b_in(b_in),
    .acc_in(acc_in), .exc_in(exc_in), .lane0_in(lane0_in), .lane1_in(lane1_in),
    .res_out(res_out), .acc_clr(acc_clr), .elem_stb(elem_stb),
    .flush_stb(flush_stb), .calc_stb(calc_stb), .pack_mode(pack_mode),
    .scale_a(scale_a), .scale_b(scale_b), .fmt_a(fmt_a), .bm_a(bm_a),
    .fmt_b(fmt_b), .bm_b(bm_b)
  );

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // phase and index for enabled-cycle number idx of a block
  task automatic step_of(input int idx, input bit sh, input int len,
                         output bit [2:0] ph, output bit [4:0] cn);
    int s0;
    s0 = sh ? 1 : 3;
    cn = 0;
    if (idx == 0)                 ph = 3'd0;
    else if (!sh && idx == 1)     ph = 3'd1;
    else if (!sh && idx == 2)     ph = 3'd2;
    else if (idx < s0 + len)      begin ph = 3'd3; cn = 5'(idx - s0); end
    else if (idx == s0 + len)     ph = 3'd4;
    else if (idx == s0 + len + 1) ph = 3'd5;
    else                          begin ph = 3'd6; cn = 5'(idx - s0 - len - 2); end
  endtask

  function automatic bit [7:0] probe_exp(input bit [3:0] sel, input bit [2:0] ph, input bit [4:0] cn,
                                         input bit e, input bit [3:0] stb, input bit [31:0] acc,
                                         input bit [7:0] exc, input bit [7:0] l0, input bit [7:0] l1);
    case (sel)
      4'd0: return {ph, cn};
      4'd1: return exc;
      4'd2: return acc[31:24];
      4'd3: return acc[23:16];
      4'd4: return acc[15:8];
      4'd5: return acc[7:0];
      4'd6: return l0;
      4'd7: return l1;
      4'd8: return {e, stb, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic run_blk(input bit [7:0] ma, input bit [7:0] mb, input bit [7:0] sa, input bit [7:0] ca,
                         input bit [7:0] sb, input bit [7:0] cb, input int stallp, input bit first);
    bit sh, pk;
    int len, total, idx;
    bit [31:0] res;
    sh = ma[7];
    pk = mb[6];
    len = pk ? 16 : 32;
    total = (sh ? 1 : 3) + len + 6;
    idx = 0;
    res = 0;
    while (idx < total) begin
      bit e, dbg;
      bit [2:0] ph;
      bit [4:0] cn;
      bit [3:0] sel, stb;
      bit [7:0] hsrc, exp_o;
      bit [31:0] accv;
      string otag, stag;
      @(negedge clk);
      e = ($urandom_range(99) >= stallp);
      step_of(idx, sh, len, ph, cn);
      accv = $urandom;
      en = e;
      acc_in = accv;
      exc_in = 8'($urandom);
      lane0_in = 8'($urandom);
      lane1_in = 8'($urandom);
      a_in = 8'($urandom);
      b_in = 8'($urandom);
      if (e) begin
        case (ph)
          3'd0: begin a_in = ma; b_in = mb; end
          3'd1: begin a_in = sa; b_in = ca; end
          3'd2: begin a_in = sb; b_in = cb; end
          default: ;
        endcase
      end
      #1;
      if (ph == 3'd5 && e) res = accv;
      stb = {e && ph == 3'd0, e && ph == 3'd3, e && ph == 3'd4, e && ph == 3'd5};
      hsrc = (ph == 3'd0) ? prev_ma : ma;
      dbg = hsrc[6];
      sel = hsrc[3:0];
      case (ph)
        3'd6: begin exp_o = res[31 - 8*cn -: 8]; otag = "R6 result byte"; end
        3'd4: begin exp_o = dbg ? ma : 8'h00; otag = dbg ? "R8 flush echo" : "R7 quiet flush"; end
        3'd5: begin exp_o = 8'h00; otag = "R8 calc zero"; end
        default: begin
          exp_o = dbg ? probe_exp(sel, ph, cn, e, stb, accv, exc_in, lane0_in, lane1_in) : 8'h00;
          otag = dbg ? "R9 probe" : "R7 quiet";
        end
      endcase
      if (!e)                        stag = "R10 stall strobes";
      else if (ph == 3'd0 && !first) stag = "R11 next header";
      else if (pk)                   stag = "R5 packed strobes";
      else                           stag = "R2 strobes";
      chk(otag, res_out, exp_o);
      chk(stag, {acc_clr, elem_stb, flush_stb, calc_stb}, stb);
      if (e) idx++;
    end
    prev_ma = ma;
    if (!sh) begin
      e_sa = sa; e_ca = ca; e_sb = sb; e_cb = cb;
    end
    chk(sh ? "R4 scale_a kept" : "R3 scale_a", scale_a, e_sa);
    chk(sh ? "R4 scale_b kept" : "R3 scale_b", scale_b, e_sb);
    chk(sh ? "R4 cfg_a kept" : "R3 fmt/bm a", {fmt_a, bm_a}, e_ca);
    chk(sh ? "R4 cfg_b kept" : "R3 fmt/bm b", {fmt_b, bm_b}, e_cb);
    chk("R5 pack_mode", pack_mode, pk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; en = 1'b0; a_in = 0; b_in = 0; acc_in = 0;
    exc_in = 0; lane0_in = 0; lane1_in = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset res_out", res_out, 0);
    chk("R1 reset strobes", {acc_clr, elem_stb, flush_stb, calc_stb}, 0);
    chk("R1 reset cfg", {scale_a, scale_b, fmt_a, bm_a, fmt_b, bm_b, pack_mode}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 idle res_out", res_out, 0);
    chk("R1 idle strobes", {acc_clr, elem_stb, flush_stb, calc_stb}, 0);
    chk("R1 idle cfg", {scale_a, scale_b, fmt_a, bm_a, fmt_b, bm_b, pack_mode}, 0);

    run_blk(8'h00, 8'h00, 8'h85, 8'h3A, 8'h70, 8'hC5, 0, 1'b1);
    for (int s = 0; s < 10; s++)
      run_blk(8'h40 | 8'(s), 8'h00, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 10, 1'b0);
    run_blk(8'h80, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 0, 1'b0);
    run_blk(8'hC8, 8'h40, 8'h11, 8'h22, 8'h33, 8'h44, 0, 1'b0);
    run_blk(8'h40, 8'h40, 8'h7F, 8'hE1, 8'h80, 8'h1F, 0, 1'b0);
    run_blk(8'h40, 8'h00, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 60, 1'b0);
    run_blk(8'hC0, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 60, 1'b0);
    for (int k = 0; k < 20; k++)
      run_blk(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
              8'($urandom), 8'($urandom), 15, 1'b0);
    summary();
    $finish;
  end
endmodule